// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block accepts one warp-wide load request and reduces it to the smallest list of aligned memory segment transactions that serves every active lane. A request carries one byte address per lane for all 32 lanes, a lane-active mask and an access size: a 4-byte word or a 16-byte vector. Lanes whose addresses fall in the same aligned segment are served by one transaction. The segment size is a parameter and defaults to 128 bytes. If consecutive lanes read consecutive aligned words, the whole warp needs one transaction. If every lane lands in its own segment, the warp needs 32.

Transactions leave one at a time on a valid/ready output. Each one carries the segment base address and the mask of the lanes it serves. They come out in ascending order of the lowest lane each one serves. A one-cycle done pulse closes the list. In vector mode, every active lane must be 16-byte aligned. If any active lane is not, the block drops the request, raises a misalignment flag together with done and issues nothing. The block takes a new request only when it is idle.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken on a cycle where both `req_valid` and `req_ready` are high, and `req_ready` stays low from the cycle after acceptance until the cycle after done.
- R2: Every transaction base equals the address of a lane it serves with its low log2(SEG_BYTES) bits cleared. With the default of 128 bytes, bits [6:0] of `txn_base` are zero.
- R3: Each transaction's lane mask holds every not-yet-served active lane whose segment equals the base. Across one request, each active lane is served exactly once and no inactive lane is ever served.
- R4: Transactions are issued in strictly ascending order of the lowest lane index in their mask, whatever the address order.
- R5: With word size (`req_vec`=0), lane i reading base+4*i from a 128-byte-aligned base gives one transaction with mask 0xFFFFFFFF. The same pattern from a base 64 bytes past a segment boundary gives two transactions.
- R6: When lane addresses are spaced a full segment or more apart, the block issues 32 transactions, each with exactly one lane bit set.
- R7: With vector size (`req_vec`=1), lane i reading base+16*i from an aligned base gives four transactions, each serving eight consecutive lanes.
- R8: In vector mode, an active lane whose address bits [3:0] are non-zero causes `misalign` and `done` to be high together in the cycle after acceptance, with no transaction. A misaligned address on an inactive lane has no effect.
- R9: An all-zero lane mask gives `done` in the cycle after acceptance, with no transaction and `misalign` low.
- R10: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_base` and `txn_lanes` hold their values into the next cycle.
- R11: `done` is high for exactly one cycle per request. For a request that issues transactions, it comes in the cycle after the last transaction handshake and never alongside `txn_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Lane-active mask, bit i is lane i |
| req_vec | input | 1 | 0 = 4-byte access, 1 = 16-byte access |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_base | output | ADDR_W | Aligned segment base address |
| txn_lanes | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle end-of-list pulse |
| misalign | output | 1 | Vector request dropped for misalignment, high with done |

## Verification
Properties check the following on every cycle: the transaction base stays aligned, the mask holds only pending lanes, no lower-indexed pending lane is skipped, outputs hold under backpressure, done is a single cycle apart from any transaction, and the error cycle carries no transaction. Only the bench scenarios can show the rest, because each needs a reference list worked out from the lane addresses. That covers the exact grouping of lanes into segments, the transaction count for contiguous, strided, vector, reversed and random patterns, the empty-mask and misalignment timing, and the fact that an inactive misaligned lane changes nothing.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ERR  = 2'd2
    } coal_state_e;

    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_VEC  = 1'b1
    } coal_size_e;

    localparam int VEC_BYTES = 16;
    localparam int VEC_OFF_W = $clog2(VEC_BYTES);

    function automatic logic [31:0] low_ones(input int bits);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < bits) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/coal_first_lane.sv
module coal_first_lane #(
    parameter int LANES = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] lanes,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = |lanes;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (lanes[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 7
) (
    input  logic [LANES*ADDR_W-1:0] addrs,
    input  logic [LANES-1:0]        pending,
    input  logic [ADDR_W-1:0]       seg_base,
    output logic [LANES-1:0]        hit
);
    localparam logic [ADDR_W-1:0] SEG_KEEP = ~ADDR_W'(coal_pkg::low_ones(OFF_W));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] lane_seg;
        assign lane_seg = addrs[g*ADDR_W +: ADDR_W] & SEG_KEEP;
        assign hit[g]   = pending[g] && (lane_seg == seg_base);
    end
endmodule

// File: rtl/coal_align_check.sv
module coal_align_check #(
    parameter int LANES = 32
) (
    input  logic [LANES*coal_pkg::VEC_OFF_W-1:0] low_bits,
    input  logic [LANES-1:0]                     active,
    input  logic                                 vec_mode,
    output logic                                 bad
);
    localparam int W = coal_pkg::VEC_OFF_W;
    logic [LANES-1:0] lane_bad;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bad[g] = active[g] && (low_bits[g*W +: W] != '0);
    end

    assign bad = vec_mode && (|lane_bad);
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    localparam int OFF_W    = $clog2(SEG_BYTES),
    localparam int IDX_W    = $clog2(LANES),
    localparam int VW       = coal_pkg::VEC_OFF_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    input  logic                    req_vec,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic [LANES-1:0]        txn_lanes,
    output logic                    done,
    output logic                    misalign
);
    import coal_pkg::*;

    localparam logic [ADDR_W-1:0] SEG_KEEP = ~ADDR_W'(low_ones(OFF_W));

    coal_state_e             state_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        pend_q;

    logic [LANES*VW-1:0]     req_low;
    logic                    req_bad;
    logic [IDX_W-1:0]        lead_idx;
    logic                    lead_any;
    logic [ADDR_W-1:0]       lead_seg;
    logic [LANES-1:0]        seg_hit;
    logic                    accept;
    logic                    fire;

    for (genvar g = 0; g < LANES; g++) begin : g_low
        assign req_low[g*VW +: VW] = req_addr[g*ADDR_W +: VW];
    end

    coal_align_check #(.LANES(LANES)) u_align (
        .low_bits (req_low),
        .active   (req_mask),
        .vec_mode (req_vec == SZ_VEC),
        .bad      (req_bad)
    );

    coal_first_lane #(.LANES(LANES)) u_first (
        .lanes (pend_q),
        .idx   (lead_idx),
        .any   (lead_any)
    );

    assign lead_seg = addr_q[lead_idx*ADDR_W +: ADDR_W] & SEG_KEEP;

    coal_seg_match #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
        .addrs    (addr_q),
        .pending  (pend_q),
        .seg_base (lead_seg),
        .hit      (seg_hit)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign txn_valid = (state_q == ST_RUN) && lead_any;
    assign txn_base  = lead_seg;
    assign txn_lanes = seg_hit;
    assign fire      = txn_valid && txn_ready;
    assign done      = ((state_q == ST_RUN) && !lead_any) || (state_q == ST_ERR);
    assign misalign  = (state_q == ST_ERR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    addr_q  <= req_addr;
                    pend_q  <= req_bad ? '0 : req_mask;
                    state_q <= req_bad ? ST_ERR : ST_RUN;
                end
                ST_RUN: begin
                    if (fire)           pend_q  <= pend_q & ~seg_hit;
                    else if (!lead_any) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checks guarding the issue path
    logic [LANES-1:0] low_served;
    logic [LANES-1:0] below_low;
    assign low_served = txn_lanes & (~txn_lanes + 1'b1);
    assign below_low  = low_served - 1'b1;

    a_r2_base_aligned: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_base[OFF_W-1:0] == '0));

    a_r3_lanes_pending: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_lanes != '0) && ((txn_lanes & ~pend_q) == '0));

    a_r4_no_lower_skipped: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> ((pend_q & below_low) == '0));

    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_lanes));

    a_r8_error_quiet: assert property (@(posedge clk) disable iff (rst)
        misalign |-> done && !txn_valid);

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_apart: assert property (@(posedge clk) disable iff (rst)
        done |-> !txn_valid && !req_ready);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !txn_valid && !done);

endmodule

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;
    localparam int L   = 32;
    localparam int AW  = 32;
    localparam int SEG = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [L*AW-1:0] req_addr = '0;
    logic [L-1:0]  req_mask = '0;
    logic          req_vec = 1'b0;
    logic          txn_valid;
    logic          txn_ready = 1'b1;
    logic [AW-1:0] txn_base;
    logic [L-1:0]  txn_lanes;
    logic          done;
    logic          misalign;

    always #4 clk = ~clk;

    warp_coalescer #(.LANES(L), .ADDR_W(AW), .SEG_BYTES(SEG)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .req_vec(req_vec),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_base(txn_base), .txn_lanes(txn_lanes),
        .done(done), .misalign(misalign)
    );

    typedef struct {
        logic [AW-1:0] base;
        logic [L-1:0]  lanes;
    } exp_t;

    exp_t          exp_q[$];
    bit            exp_err;
    bit            done_seen;
    bit            mon_en = 1'b0;
    bit            backpress = 1'b0;
    string         tag = "R1";
    logic [AW-1:0] lane_a[L];
    int            checks = 0;
    int            fails = 0;
    int            cyc = 0;
    bit            prev_stall = 1'b0;
    bit            prev_done = 1'b0;
    logic [AW-1:0] prev_base;
    logic [L-1:0]  prev_lanes;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) cyc++;

    initial begin
        wait (cyc > 150000);
        checks++;
        fails++;
        $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Monitor: sets ready for this cycle, then samples the settled outputs
    always @(negedge clk) begin
        if (mon_en) begin
            txn_ready = backpress ? ($urandom_range(0, 2) != 0) : 1'b1;
            #1;
            if (prev_stall) begin
                chk(txn_valid === 1'b1, "R10", "valid held", 64'(txn_valid), 64'd1);
                chk(txn_base === prev_base, "R10", "base held", 64'(txn_base), 64'(prev_base));
                chk(txn_lanes === prev_lanes, "R10", "lanes held", 64'(txn_lanes), 64'(prev_lanes));
            end
            prev_stall = txn_valid && !txn_ready;
            prev_base  = txn_base;
            prev_lanes = txn_lanes;
            if (txn_valid && txn_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, tag, "unexpected transaction", 64'(txn_lanes), 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(txn_base === e.base, tag, "txn base (R2)", 64'(txn_base), 64'(e.base));
                    chk(txn_lanes === e.lanes, tag, "txn lanes (R3 R4)", 64'(txn_lanes), 64'(e.lanes));
                end
            end
            if (done) begin
                chk(prev_done == 1'b0, "R11", "done longer than one cycle", 64'd1, 64'd0);
                chk(exp_q.size() == 0, tag, "done before list end (R11)", 64'(exp_q.size()), 64'd0);
                chk(misalign === exp_err, "R8", "misalign at done", 64'(misalign), 64'(exp_err));
                chk(txn_valid === 1'b0, "R11", "valid with done", 64'(txn_valid), 64'd0);
                done_seen = 1'b1;
            end
            prev_done = done;
        end
    end

    // Driver: builds the reference list, then presents the request
    task automatic run_req(input string t, input bit vec, input logic [L-1:0] mask);
        logic [L-1:0] covered;
        covered = '0;
        exp_q.delete();
        exp_err = 1'b0;
        for (int i = 0; i < L; i++) begin
            if (vec && mask[i] && lane_a[i][3:0] != 4'd0) exp_err = 1'b1;
        end
        if (!exp_err) begin
            for (int i = 0; i < L; i++) begin
                if (mask[i] && !covered[i]) begin
                    exp_t e;
                    e.base  = lane_a[i] & ~AW'(SEG - 1);
                    e.lanes = '0;
                    for (int j = i; j < L; j++) begin
                        if (mask[j] && ((lane_a[j] & ~AW'(SEG - 1)) == e.base)) e.lanes[j] = 1'b1;
                    end
                    covered |= e.lanes;
                    exp_q.push_back(e);
                end
            end
        end
        @(negedge clk);
        #2;
        tag = t;
        done_seen = 1'b0;
        chk(req_ready === 1'b1, "R1", "ready while idle", 64'(req_ready), 64'd1);
        for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = lane_a[i];
        req_mask  = mask;
        req_vec   = vec;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        #2;
        chk(req_ready === 1'b0, "R1", "ready after accept", 64'(req_ready), 64'd0);
        if (exp_err || mask == '0) begin
            chk(done === 1'b1, exp_err ? "R8" : "R9", "done one cycle after accept", 64'(done), 64'd1);
            chk(txn_valid === 1'b0, exp_err ? "R8" : "R9", "no txn", 64'(txn_valid), 64'd0);
        end
        while (!done_seen) @(negedge clk);
        @(negedge clk);
        #2;
        chk(req_ready === 1'b1, "R1", "ready after done", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
        chk(txn_valid === 1'b0, "R1", "reset valid", 64'(txn_valid), 64'd0);
        chk(done === 1'b0, "R11", "reset done", 64'(done), 64'd0);
        chk(misalign === 1'b0, "R8", "reset misalign", 64'(misalign), 64'd0);
        mon_en = 1'b1;

        for (int i = 0; i < L; i++) lane_a[i] = 32'h1000 + 32'(4 * i);
        run_req("R5", 1'b0, '1);
        for (int i = 0; i < L; i++) lane_a[i] = 32'h1040 + 32'(4 * i);
        run_req("R5", 1'b0, '1);

        backpress = 1'b1;
        for (int i = 0; i < L; i++) lane_a[i] = 32'h2000 + 32'(SEG * i);
        run_req("R6", 1'b0, '1);

        for (int i = 0; i < L; i++) lane_a[i] = 32'h4000 + 32'(16 * i);
        run_req("R7", 1'b1, '1);

        lane_a[5] = lane_a[5] + 32'd4;
        run_req("R8", 1'b1, '1);
        run_req("R8", 1'b1, 32'hFFFF_FFDF);

        run_req("R9", 1'b0, '0);

        for (int i = 0; i < L; i++) lane_a[i] = 32'h8000 + 32'(SEG * (31 - i));
        run_req("R4", 1'b0, 32'hF0F0_FFFF);

        for (int k = 0; k < 30; k++) begin
            bit v;
            v = ($urandom_range(0, 1) == 1);
            for (int i = 0; i < L; i++) begin
                lane_a[i] = 32'h0001_0000 + 32'($urandom_range(0, 1023));
                if (v) lane_a[i][3:0] = 4'd0;
            end
            run_req("R3", v, 32'($urandom));
        end

        backpress = 1'b0;
        mon_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule